// File: doc/BRIEF.md
# Partitionable Bit-Slice SIMD ALU

This block is an 8-bit arithmetic unit built from eight identical 1-bit slices. A carry-cut mask decides where the carry chain breaks between neighbouring slices. With no cuts, one operand pair forms a single 8-bit operation. Each set mask bit starts a new independent lane, so one issue can carry several narrower operations of equal or unequal width. For example, the mask can give two 4-bit lanes, four 2-bit lanes, or a 6-bit lane beside a 2-bit lane.

Each lane adds or subtracts on its own. Bitwise AND and XOR act on the whole word, whatever the lane layout. The result and a per-lane carry vector are registered, and a valid flag follows the issue by one clock.

Top module: `seg_alu`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `result` and `lane_cout` are all 0.
- R2: With `cut_mask` = 0 and `op_sel` = 00 (add), `result` is `op_a + op_b` modulo 256, and `lane_cout[7]` is the carry out of bit 7.
- R3: Setting `cut_mask[i]` cuts the carry between slice i and slice i+1, so each lane sums on its own modulo 2^width. Mask 0001000 gives two 4-bit lanes, 0101010 gives four 2-bit lanes, and 0100000 gives a 6-bit lane (bits 5:0) beside a 2-bit lane (bits 7:6).
- R4: With `op_sel` = 01 (subtract), each lane gives A − B modulo 2^width, computed as A + ~B + 1. The lane's carry is 1 exactly when A ≥ B within that lane.
- R5: With `op_sel` = 10, `result` is `op_a & op_b`. With `op_sel` = 11, it is `op_a ^ op_b`. In both cases the mask has no effect on `result` and `lane_cout` is all 0.
- R6: `lane_cout[i]` can be 1 only where i is the top bit of a lane, that is i = 7 or `cut_mask[i]` = 1.
- R7: `result` and `lane_cout` appear one clock after an issue with `in_valid` = 1, and `out_valid` equals `in_valid` delayed by one clock.
- R8: While `in_valid` = 0, `result` and `lane_cout` hold their last values, whatever the operands, mask and op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue strobe for this cycle's operands |
| op_a | input | 8 | First operand, packed lanes |
| op_b | input | 8 | Second operand, packed lanes |
| cut_mask | input | 7 | Bit i cuts the carry between slice i and slice i+1 |
| op_sel | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 8 | Registered packed result |
| lane_cout | output | 8 | Registered carry out of each lane, placed at the lane's top bit |

## Verification
The clocked properties assume that `in_valid` is low while reset is held. They also assume that operands, mask and op are stable around the sampling edge of any issue cycle. The bench drives every input on the falling edge and keeps `in_valid` at 0 until after reset is released. Directed tasks cover each lane layout named in the requirements, with values chosen to make carries reach cut points. A reference that works lane by lane, written from the requirements, supplies the expected words.

// File: rtl/segalu_pkg.sv
// Package: shared width and operation encoding for the segmented ALU.
// Assumes an operand width of at least 2 bits.
package segalu_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
// One-bit slice: a full adder with an optional B inversion, plus bitwise
// AND/XOR. It drives carry-out only for arithmetic ops.
// Assumes the carry-in is chosen outside the slice.
module alu_slice
    import segalu_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    input  alu_op_e op,
    output logic    y,
    output logic    cout
);
    logic b_eff;
    logic arith;

    // Purpose: invert B for subtraction and compute the slice output and carry.
    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        arith = (op == OP_ADD) || (op == OP_SUB);
        cout  = arith ? ((a & b_eff) | (cin & (a ^ b_eff))) : 1'b0;
        unique case (op)
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = a ^ b_eff ^ cin;
        endcase
    end
endmodule

// File: rtl/carry_chain.sv
// Chains W slices. Wherever a cut bit is set, the next slice takes the
// lane carry-in (0 for add, 1 for subtract) instead of the ripple carry.
// Exposes the raw carry-out of every slice.
module carry_chain
    import segalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-2:0] cut,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic [W-1:0] co
);
    logic         lane_cin;
    logic [W-1:0] cin_v;

    // Purpose: the carry seed of every lane follows the operation.
    always_comb lane_cin = (op == OP_SUB);

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == 0) begin : g_first
            assign cin_v[i] = lane_cin;
        end else begin : g_next
            assign cin_v[i] = cut[i-1] ? lane_cin : co[i-1];
        end
        alu_slice u_slice (
            .a   (a[i]),
            .b   (b[i]),
            .cin (cin_v[i]),
            .op  (op),
            .y   (y[i]),
            .cout(co[i])
        );
    end
endmodule

// File: rtl/lane_carry.sv
// Keeps each slice carry only at lane tops (bit W-1 or any cut bit), and
// clears all carries for bitwise operations.
module lane_carry
    import segalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-2:0] cut,
    input  alu_op_e      op,
    input  logic [W-1:0] co,
    output logic [W-1:0] lane_co
);
    logic [W-1:0] tops;

    // Purpose: select the slice carries that leave a lane.
    always_comb begin
        tops    = {1'b1, cut};
        lane_co = (op == OP_AND || op == OP_XOR) ? '0 : (co & tops);
    end
endmodule

// File: rtl/seg_alu.sv
// Top: segmented SIMD ALU with registered outputs and one-cycle latency.
// Assumes in_valid is low during reset and that inputs are stable around
// the clock edge. Outputs hold while in_valid is low.
module seg_alu
    import segalu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-2:0] cut_mask,
    input  logic [1:0]   op_sel,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic [W-1:0] lane_cout
);
    alu_op_e      op;
    logic [W-1:0] y_c;
    logic [W-1:0] co_c;
    logic [W-1:0] lane_co_c;

    // Purpose: map the raw select onto the operation type.
    always_comb op = alu_op_e'(op_sel);

    carry_chain #(.W(W)) u_chain (
        .a  (op_a),
        .b  (op_b),
        .cut(cut_mask),
        .op (op),
        .y  (y_c),
        .co (co_c)
    );

    lane_carry #(.W(W)) u_lanes (
        .cut    (cut_mask),
        .op     (op),
        .co     (co_c),
        .lane_co(lane_co_c)
    );

    // Purpose: register the result and lane carries on issue; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            lane_cout <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= y_c;
                lane_cout <= lane_co_c;
            end
        end
    end

    // R7: valid is the issue strobe delayed by one clock
    p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: uncut add matches a full-width sum
    p_full_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b00 && cut_mask == '0)
        |=> ({lane_cout[W-1], result} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));
    // R5: bitwise AND reaches the output and raises no carry
    p_and_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10) |=> (result == ($past(op_a) & $past(op_b)) && lane_cout == '0));
    // R5: bitwise XOR raises no carry
    p_xor_nocarry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11) |=> (lane_cout == '0));
    // R6: carries appear only at lane tops
    p_cout_tops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((lane_cout & ~{1'b1, $past(cut_mask)}) == '0));
    // R8: outputs hold while idle
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(lane_cout)));
endmodule

// File: tb/seg_alu_test.sv
module seg_alu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [6:0] cut_mask = '0;
    logic [1:0] op_sel = '0;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] lane_cout;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    seg_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .cut_mask(cut_mask), .op_sel(op_sel),
        .out_valid(out_valid), .result(result), .lane_cout(lane_cout)
    );

    // Lane-by-lane reference written from the requirements.
    function automatic void ref_model(input logic [7:0] a, input logic [7:0] b,
                                      input logic [6:0] m, input logic [1:0] op,
                                      output logic [7:0] r, output logic [7:0] c);
        int lo;
        lo = 0;
        r  = '0;
        c  = '0;
        if (op[1]) begin
            r = op[0] ? (a ^ b) : (a & b);
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (i == 7 || m[i]) begin
                    int w, msk, fa, fb, s;
                    w   = i - lo + 1;
                    msk = (1 << w) - 1;
                    fa  = (int'(a) >> lo) & msk;
                    fb  = (int'(b) >> lo) & msk;
                    if (op[0]) fb = (~fb) & msk;
                    s   = fa + fb + (op[0] ? 1 : 0);
                    for (int k = 0; k < w; k++) r[lo+k] = s[k];
                    c[i] = s[w];
                    lo   = i + 1;
                end
            end
        end
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation, wait one clock and compare with the reference.
    task automatic issue(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic [6:0] m, input logic [1:0] op);
        logic [7:0] er, ec;
        ref_model(a, b, m, op, er, ec);
        @(negedge clk);
        op_a = a; op_b = b; cut_mask = m; op_sel = op; in_valid = 1'b1;
        @(posedge clk);
        #1;
        check8(req, "result", result, er);
        check8(req, "lane_cout", lane_cout, ec);
        check8("R7", "out_valid", {7'b0, out_valid}, 8'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check8("R1", "reset result", result, 8'h00);
        check8("R1", "reset lane_cout", lane_cout, 8'h00);
        check8("R1", "reset out_valid", {7'b0, out_valid}, 8'h00);
    endtask

    task automatic t_full_add;  // R2
        issue("R2", 8'hFF, 8'h01, 7'h00, 2'b00);
        issue("R2", 8'h7F, 8'h01, 7'h00, 2'b00);
        issue("R2", 8'hA5, 8'h5B, 7'h00, 2'b00);
        issue("R2", 8'h12, 8'h34, 7'h00, 2'b00);
    endtask

    task automatic t_split;  // R3, R6
        issue("R3", 8'h0F, 8'h01, 7'b0001000, 2'b00);  // 4+4: low carry stops at bit 4
        issue("R3", 8'hFF, 8'h11, 7'b0001000, 2'b00);
        issue("R3", 8'hFF, 8'h55, 7'b0101010, 2'b00);  // 2+2+2+2
        issue("R3", 8'h3F, 8'h01, 7'b0100000, 2'b00);  // 6+2
        issue("R6", 8'hFF, 8'hFF, 7'b0100000, 2'b00);
        issue("R6", 8'hFF, 8'hFF, 7'b1111111, 2'b00);  // eight 1-bit lanes
        issue("R6", 8'hC7, 8'h39, 7'b0010010, 2'b00);  // 2+3+3 uneven
    endtask

    task automatic t_sub;  // R4
        issue("R4", 8'h05, 8'h03, 7'h00, 2'b01);
        issue("R4", 8'h03, 8'h05, 7'h00, 2'b01);
        issue("R4", 8'h20, 8'h11, 7'b0001000, 2'b01);  // low lane borrows
        issue("R4", 8'h1B, 8'h2B, 7'b0101010, 2'b01);
        issue("R4", 8'h40, 8'h81, 7'b0100000, 2'b01);
    endtask

    task automatic t_bitwise;  // R5
        issue("R5", 8'hF0, 8'h3C, 7'h00, 2'b10);
        issue("R5", 8'hF0, 8'h3C, 7'b1010101, 2'b10);
        issue("R5", 8'hFF, 8'hFF, 7'b0001000, 2'b11);
        issue("R5", 8'hA5, 8'h0F, 7'b1111111, 2'b11);
    endtask

    task automatic t_hold;  // R8, R7
        issue("R8", 8'h81, 8'h81, 7'h00, 2'b00);  // result 02, carry 80
        @(negedge clk);
        op_a = 8'h55; op_b = 8'hAA; cut_mask = 7'h7F; op_sel = 2'b11; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check8("R8", "held result", result, 8'h02);
        check8("R8", "held lane_cout", lane_cout, 8'h80);
        check8("R7", "idle out_valid", {7'b0, out_valid}, 8'h00);
    endtask

    task automatic t_sweep;  // R3/R4 across several layouts
        logic [6:0] masks [4] = '{7'h00, 7'b0001000, 7'b0101010, 7'b0100000};
        for (int j = 0; j < 4; j++) begin
            for (int v = 0; v < 6; v++) begin
                issue("R3", 8'(v * 37 + 11), 8'(v * 91 + 200), masks[j], 2'b00);
                issue("R4", 8'(v * 53 + 7), 8'(v * 29 + 130), masks[j], 2'b01);
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_full_add();
        t_split();
        t_sub();
        t_bitwise();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule